// File: doc/BRIEF.md
# Register Transfer Queue with Shared Memory Port Arbiter

This block sits between the rename stage and a single data cache port. When rename evicts a physical register to memory (spill) or brings one back in (fill), it pushes an entry into an eight-deep FIFO. Each entry carries the kind of transfer, a memory address that is already complete, and the physical register tag. The block needs no address logic, no disambiguation and no dependence tracking for these entries.

Each cycle the block decides who owns the memory port. If the queue holds anything, its head entry owns the port and ordinary load/store traffic waits. If the queue is empty, a pending load/store request is granted in the same cycle. Entries leave strictly in the order they were pushed, so a spill of an address always reaches the port before a later fill of that address. When the queue is full, a backpressure signal stalls rename and further pushes are dropped. Cache responses for fills come back on a response interface. One cycle after such a response is accepted, the block pulses a completion with the register tag so that the register can be marked valid.

Top module: `xfer_queue`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `fill_done` is 0, `mem_xfer` is 0, and `mem_req` follows `ins_req` alone.
- R2: While the queue holds at least one entry, the port carries the head entry (`mem_req`=1, `mem_xfer`=1) and `ins_grant` is 0 whatever `ins_req` is.
- R3: While the queue is empty, the port carries the instruction access (`mem_addr`=`ins_addr`, `mem_we`=`ins_we`, `mem_xfer`=0), and `ins_grant` = `ins_req` AND `mem_ready` in the same cycle.
- R4: Entries reach the port in push order with address and tag unchanged. `mem_we` is 1 for a spill (`push_spill`=1) and 0 for a fill.
- R5: `full` is 1 exactly when DEPTH entries are held. A push presented while `full` is 1 is dropped and never reaches the port.
- R6: The head leaves only on a cycle with `mem_ready`=1. While `mem_ready` is 0 the head's address, tag and type stay unchanged.
- R7: A response with `resp_valid`=1 and `resp_fill`=1 produces `fill_done`=1 with `fill_tag` = that `resp_tag` on the next cycle. Any other response cycle produces `fill_done`=0 on the next cycle.
- R8: A push and a pop in the same cycle keep the occupancy unchanged and preserve order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Rename requests a transfer |
| push_spill | input | 1 | 1 = spill (register to memory), 0 = fill |
| push_addr | input | AW | Precomputed memory address |
| push_tag | input | TW | Physical register tag |
| full | output | 1 | Backpressure to rename |
| ins_req | input | 1 | Load/store access pending |
| ins_we | input | 1 | Load/store is a write |
| ins_addr | input | AW | Load/store address |
| ins_grant | output | 1 | Load/store access taken this cycle |
| mem_req | output | 1 | Port request |
| mem_we | output | 1 | Port write |
| mem_addr | output | AW | Port address |
| mem_tag | output | TW | Register tag of a transfer on the port |
| mem_xfer | output | 1 | Port carries a queued transfer |
| mem_ready | input | 1 | Port accepts this cycle |
| resp_valid | input | 1 | Cache response accepted |
| resp_fill | input | 1 | Response belongs to a fill |
| resp_tag | input | TW | Register tag of the response |
| fill_done | output | 1 | Fill completion pulse |
| fill_tag | output | TW | Tag of the completed fill |

## Verification
The queue is loaded past capacity with a mix of fills and spills whose addresses and tags are arithmetic in the index. It is then drained with `mem_ready` alternating, which shows both the order and that the dropped extra push never appears. The same drain runs with `ins_req` held high, which separates strict transfer priority from a fair arbiter. A sustained push-and-pop phase checks that the pointers stay consistent when both happen together. Finally, every tag value is swept through the response interface with varying valid/fill patterns, to show that only fill responses make a pulse and that the pulse comes exactly one cycle later.

// File: rtl/xfer_queue.sv
module xfer_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic          push_spill,
  input  logic [AW-1:0] push_addr,
  input  logic [TW-1:0] push_tag,
  output logic          full,
  input  logic          ins_req,
  input  logic          ins_we,
  input  logic [AW-1:0] ins_addr,
  output logic          ins_grant,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [TW-1:0] mem_tag,
  output logic          mem_xfer,
  input  logic          mem_ready,
  input  logic          resp_valid,
  input  logic          resp_fill,
  input  logic [TW-1:0] resp_tag,
  output logic          fill_done,
  output logic [TW-1:0] fill_tag
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          q_spill [DEPTH];
  logic [AW-1:0] q_addr  [DEPTH];
  logic [TW-1:0] q_tag   [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  wire empty = (count == '0);
  wire do_push = push_valid && !full;
  wire do_pop  = !empty && mem_ready;

  assign full      = (count == CW'(DEPTH));
  assign mem_xfer  = !empty;
  assign mem_req   = mem_xfer || ins_req;
  assign mem_we    = mem_xfer ? q_spill[rd_ptr] : ins_we;
  assign mem_addr  = mem_xfer ? q_addr[rd_ptr]  : ins_addr;
  assign mem_tag   = mem_xfer ? q_tag[rd_ptr]   : '0;
  assign ins_grant = empty && ins_req && mem_ready;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) begin
      q_spill[wr_ptr] <= push_spill;
      q_addr[wr_ptr]  <= push_addr;
      q_tag[wr_ptr]   <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_done <= 1'b0;
      fill_tag  <= '0;
    end else begin
      fill_done <= resp_valid && resp_fill;
      fill_tag  <= resp_tag;
    end
  end
endmodule

module xfer_queue_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TW    = 7,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_valid,
  input logic          full,
  input logic          ins_req,
  input logic          ins_grant,
  input logic          mem_xfer,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [TW-1:0] mem_tag,
  input logic          resp_valid,
  input logic          resp_fill,
  input logic [TW-1:0] resp_tag,
  input logic          fill_done,
  input logic [TW-1:0] fill_tag,
  input logic [CW-1:0] count
);
  a_r2_queue_priority: assert property (@(posedge clk) disable iff (!rst_n)
    mem_xfer |-> !ins_grant);
  a_r3_same_cycle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_xfer && ins_req && mem_ready) |-> ins_grant);
  a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_valid && !mem_ready) |=> full);
  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r6_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_xfer && !mem_ready) |=> mem_xfer && $stable(mem_addr) && $stable(mem_tag) && $stable(mem_we));
  a_r7_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fill) |=> fill_done && fill_tag == $past(resp_tag));
  a_r7_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && resp_fill) |=> !fill_done);
endmodule

bind xfer_queue xfer_queue_chk #(.DEPTH(DEPTH), .AW(AW), .TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .full(full),
  .ins_req(ins_req), .ins_grant(ins_grant), .mem_xfer(mem_xfer),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_tag(mem_tag),
  .resp_valid(resp_valid), .resp_fill(resp_fill), .resp_tag(resp_tag),
  .fill_done(fill_done), .fill_tag(fill_tag), .count(count)
);

// File: tb/tb_xfer_queue.sv
module tb_xfer_queue;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int TW = 7;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_spill = 0;
  logic [AW-1:0] push_addr = '0;
  logic [TW-1:0] push_tag = '0;
  logic full;
  logic ins_req = 0, ins_we = 0;
  logic [AW-1:0] ins_addr = '0;
  logic ins_grant, mem_req, mem_we, mem_xfer;
  logic [AW-1:0] mem_addr;
  logic [TW-1:0] mem_tag;
  logic mem_ready = 0;
  logic resp_valid = 0, resp_fill = 0;
  logic [TW-1:0] resp_tag = '0;
  logic fill_done;
  logic [TW-1:0] fill_tag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xfer_queue #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] e_addr(int i); return AW'(32'h8000_0000 + i * 64 + 8); endfunction
  function automatic logic [TW-1:0] e_tag(int i);  return TW'(i * 5 + 3); endfunction
  function automatic logic          e_spill(int i); return (i % 3) == 0; endfunction

  task automatic set_push(input bit v, input int i);
    push_valid = v; push_spill = e_spill(i); push_addr = e_addr(i); push_tag = e_tag(i);
  endtask

  task automatic chk_head(input string req, input int i);
    chk({req, " xfer"}, mem_xfer, 1);
    chk({req, " addr"}, mem_addr, e_addr(i));
    chk({req, " tag"}, mem_tag, e_tag(i));
    chk({req, " we"}, mem_we, e_spill(i));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 full", full, 0);
    chk("R1 fill_done", fill_done, 0);
    chk("R1 xfer", mem_xfer, 0);
    chk("R1 mem_req", mem_req, 0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ins_req = (i != 7); ins_we = i[0]; ins_addr = AW'(32'h1000 + i * 4); mem_ready = (i % 4) != 2;
      #1;
      chk("R3 grant", ins_grant, ins_req && mem_ready);
      chk("R3 req", mem_req, ins_req);
      chk("R3 addr", mem_addr, ins_addr);
      chk("R3 we", mem_we, ins_we);
      chk("R3 xfer", mem_xfer, 0);
    end

    ins_req = 0; mem_ready = 0;
    for (int i = 0; i <= DEPTH; i++) begin
      @(negedge clk);
      set_push(1, i);
      #1;
      chk("R5 full", full, i == DEPTH);
      if (i > 0) chk_head("R6 held", 0);
    end
    @(negedge clk);
    set_push(1, 99);
    #1;
    chk("R5 still full", full, 1);

    @(negedge clk);
    set_push(0, 0);
    ins_req = 1; ins_addr = 32'h2222; ins_we = 1;
    begin
      int idx = 0;
      for (int k = 0; k < 4 * DEPTH && idx < DEPTH; k++) begin
        @(negedge clk);
        mem_ready = (k % 2) == 0;
        #1;
        chk_head("R4 order", idx);
        chk("R2 no grant", ins_grant, 0);
        chk("R2 req", mem_req, 1);
        if (mem_ready) idx++;
      end
      chk("R5 drained count", idx, DEPTH);
    end
    @(negedge clk);
    mem_ready = 1;
    #1;
    chk("R5 dropped push absent", mem_xfer, 0);
    chk("R3 grant after drain", ins_grant, 1);
    chk("R3 addr after drain", mem_addr, 32'h2222);

    ins_req = 0;
    @(negedge clk);
    mem_ready = 0; set_push(1, 20);
    for (int j = 21; j < 28; j++) begin
      @(negedge clk);
      mem_ready = 1; set_push(1, j);
      #1;
      chk_head("R8 push+pop", j - 1);
      chk("R8 full", full, 0);
    end
    @(negedge clk);
    set_push(0, 0);
    #1;
    chk_head("R8 last", 27);
    @(negedge clk);
    #1;
    chk("R8 empty", mem_xfer, 0);

    mem_ready = 0;
    begin
      bit pv = 0;
      logic [TW-1:0] pt = '0;
      for (int t = 0; t < (1 << TW) + 1; t++) begin
        @(negedge clk);
        #1;
        if (t > 0) begin
          chk("R7 pulse", fill_done, pv);
          if (pv) chk("R7 tag", fill_tag, pt);
        end
        resp_valid = (t % 4) != 3; resp_fill = (t % 3) != 0; resp_tag = TW'(t);
        pv = resp_valid && resp_fill; pt = resp_tag;
      end
    end
    resp_valid = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule